// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block turns five UART interrupt request lines into one pending-event store and one 8-bit identification byte that host software reads. The five sources are line-status error, receive data ready, receive timeout, transmit holding empty and modem status change. Each source has its own enable input. A source becomes pending when its request rises while it is enabled. The highest-priority pending source is encoded into the low nibble of the byte. The upper bits report whether the FIFOs are on.

A host read strobe consumes only the event being reported at that moment. Any lower-priority events stay pending and show up on later reads. The active-high interrupt output is asserted whenever any event is pending. The serial datapath, the FIFOs and the bus decode sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset no event is pending: with fifoOn low, statusByte reads 0x01 and irqOut is 0.
- R2: A pending event is recorded only on a 0-to-1 change of its request bit while its enable bit is set. A request held high does not record the event again after it has been consumed.
- R3: A request whose enable bit is clear records nothing, and statusByte keeps its previous value.
- R4: statusByte[3:0] gives the source code: line-status error 0110, receive data ready 0100, receive timeout 1100, transmit holding empty 0010, modem status 0000, nothing pending 0001. The request and enable bit positions are 0 line error, 1 receive ready, 2 receive timeout, 3 transmit empty, 4 modem.
- R5: The reported source is the highest in priority among the pending ones, in this order: line error, then receive ready, then receive timeout (receive ready comes before timeout within the same level), then transmit empty, then modem.
- R6: On a clock edge where statusRead is high, only the source shown on statusByte is cleared. The next pending source in priority order becomes visible after that edge.
- R7: A request that rises in the same cycle as a read is recorded, even when it belongs to the source being cleared.
- R8: statusByte[7:6] is 11 when fifoOn is high and 00 otherwise. statusByte[5:4] is always 00.
- R9: irqOut is high exactly when statusByte[0] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | 5 | Interrupt request levels, one per source |
| enIn | input | 5 | Per-source enables |
| statusRead | input | 1 | Host read strobe for the identification byte |
| fifoOn | input | 1 | FIFOs-enabled indication |
| irqOut | output | 1 | Interrupt pending, active high |
| statusByte | output | 8 | Identification byte |

## Verification
A table of stimulus vectors raises different subsets of sources, under different enable masks and both FIFO settings. Each vector is then drained read by read, and every read is compared against a priority model kept in the bench. Single-source vectors check the code of each source. Combined subsets check the priority order, including the tie inside the receive level. Vectors with enables cleared show that masked requests are dropped. Directed cases cover a request held high across a read, and a new request arriving in the same cycle as a read, both for a different source and for the source being cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  localparam int CODEW = 4;

  // Index order is also the priority order: index 0 wins.
  typedef enum logic [2:0] {
    SRC_LINE    = 3'd0,
    SRC_RXRDY   = 3'd1,
    SRC_RXTMO   = 3'd2,
    SRC_TXEMPTY = 3'd3,
    SRC_MODEM   = 3'd4
  } srcIdx_e;

  typedef struct packed {
    logic [NSRC-1:0]  clrMask;
    logic [CODEW-1:0] idCode;
  } ctrlStrobe_t;

  localparam logic [CODEW-1:0] CODE_IDLE = 4'b0001;

  function automatic logic [CODEW-1:0] codeOf(input int idx);
    case (idx)
      int'(SRC_LINE):    codeOf = 4'b0110;
      int'(SRC_RXRDY):   codeOf = 4'b0100;
      int'(SRC_RXTMO):   codeOf = 4'b1100;
      int'(SRC_TXEMPTY): codeOf = 4'b0010;
      int'(SRC_MODEM):   codeOf = 4'b0000;
      default:           codeOf = CODE_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pending,
  input  logic            statusRead,
  output ctrlStrobe_t     strobes
);
  logic [NSRC-1:0]  winOh;
  logic [CODEW-1:0] winCode;

  // Walk from lowest priority up so the highest pending source is kept last.
  always_comb begin
    winOh   = '0;
    winCode = CODE_IDLE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        winOh    = '0;
        winOh[i] = 1'b1;
        winCode  = codeOf(i);
      end
    end
  end

  always_comb begin
    strobes.idCode  = winCode;
    strobes.clrMask = statusRead ? winOh : '0;
  end
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqIn,
  input  logic [NSRC-1:0] enIn,
  input  logic            fifoOn,
  input  ctrlStrobe_t     strobes,
  output logic [NSRC-1:0] pending,
  output logic [7:0]      statusByte
);
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : gSrc
      logic reqPrev;
      logic rise;
      assign rise = reqIn[g] & ~reqPrev & enIn[g];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          reqPrev    <= 1'b0;
          pending[g] <= 1'b0;
        end else begin
          reqPrev    <= reqIn[g];
          // a new event wins over the clear so it is never lost
          pending[g] <= (pending[g] & ~strobes.clrMask[g]) | rise;
        end
      end
    end
  endgenerate

  assign statusByte = {{2{fifoOn}}, 2'b00, strobes.idCode};
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] reqIn,
  input  logic [NSRC-1:0] enIn,
  input  logic            statusRead,
  input  logic            fifoOn,
  output logic            irqOut,
  output logic [7:0]      statusByte
);
  logic [NSRC-1:0] pending;
  ctrlStrobe_t     strobes;

  uart_irq_ctrl u_ctrl (
    .pending    (pending),
    .statusRead (statusRead),
    .strobes    (strobes)
  );

  uart_irq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .enIn       (enIn),
    .fifoOn     (fifoOn),
    .strobes    (strobes),
    .pending    (pending),
    .statusByte (statusByte)
  );

  assign irqOut = |pending;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] reqIn,
  input logic [NSRC-1:0] enIn,
  input logic            statusRead,
  input logic            fifoOn,
  input logic            irqOut,
  input logic [7:0]      statusByte
);
  logic [NSRC-1:0] reqSeen;
  logic [NSRC-1:0] riseC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSeen <= '0;
    else       reqSeen <= reqIn;
  end
  assign riseC = reqIn & ~reqSeen & enIn;

  p_irq_vs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut != statusByte[0]);

  p_upper_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[5:4] == 2'b00 && statusByte[7:6] == {2{fifoOn}});

  p_legal_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:0] inside {4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000, 4'b0001});

  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && riseC == '0) |=> statusByte[0]);

  p_line_rise_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    riseC[0] |=> (statusByte[3:0] == 4'b0110));

  p_read_consumes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !statusByte[0] && riseC == '0) |=>
      statusByte[3:0] != $past(statusByte[3:0]));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqIn      (reqIn),
  .enIn       (enIn),
  .statusRead (statusRead),
  .fifoOn     (fifoOn),
  .irqOut     (irqOut),
  .statusByte (statusByte)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] reqIn = '0;
  logic [4:0] enIn = '0;
  logic       statusRead = 1'b0;
  logic       fifoOn = 1'b0;
  logic       irqOut;
  logic [7:0] statusByte;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  uart_irq_ident uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .enIn(enIn),
    .statusRead(statusRead), .fifoOn(fifoOn),
    .irqOut(irqOut), .statusByte(statusByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {enable[4:0], raise[4:0], fifo, expected first byte[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {5'b11111, 5'b00001, 1'b0, 8'h06},
    {5'b11111, 5'b11111, 1'b1, 8'hC6},
    {5'b11111, 5'b00110, 1'b0, 8'h04},
    {5'b11111, 5'b00100, 1'b1, 8'hCC},
    {5'b11111, 5'b11000, 1'b0, 8'h02},
    {5'b11111, 5'b10000, 1'b0, 8'h00},
    {5'b11110, 5'b00001, 1'b0, 8'h01},
    {5'b01011, 5'b11111, 1'b1, 8'hC6},
    {5'b10100, 5'b10111, 1'b0, 8'h0C},
    {5'b11111, 5'b11010, 1'b1, 8'hC4}
  };

  function automatic logic [3:0] refCode(input logic [4:0] m);
    if (m[0])      return 4'b0110;
    else if (m[1]) return 4'b0100;
    else if (m[2]) return 4'b1100;
    else if (m[3]) return 4'b0010;
    else if (m[4]) return 4'b0000;
    else           return 4'b0001;
  endfunction

  function automatic logic [4:0] dropTop(input logic [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) begin m[i] = 1'b0; return m; end
    return m;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkByte(input string req, input logic [7:0] exp);
    checks++;
    if (statusByte !== exp || irqOut !== ~exp[0]) begin
      failures++;
      $display("FAIL %s: statusByte=%h irqOut=%b expected %h irq %b",
               req, statusByte, irqOut, exp, ~exp[0]);
    end
  endtask

  task automatic doRead();
    statusRead = 1'b1;
    tick();
    statusRead = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] remain;
    logic [1:0] top;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkByte("R1 reset", 8'h01);

    // vector table, each one drained read by read (R2 R3 R4 R5 R6 R8 R9)
    for (int v = 0; v < NV; v++) begin
      enIn   = VEC[v][18:14];
      fifoOn = VEC[v][8];
      reqIn  = VEC[v][13:9];
      tick();
      reqIn = '0;
      checkByte("R4/R5 first byte", VEC[v][7:0]);
      remain = VEC[v][13:9] & VEC[v][18:14];
      top = fifoOn ? 2'b11 : 2'b00;
      while (remain != '0) begin
        checkByte("R6 drain", {top, 2'b00, refCode(remain)});
        doRead();
        remain = dropTop(remain);
      end
      checkByte("R3/R8 empty after drain", {top, 2'b00, 4'b0001});
      tick();
    end

    // R2: level held across a read does not re-arm
    fifoOn = 1'b0;
    enIn = 5'b11111;
    reqIn = 5'b01000;
    tick();
    checkByte("R2 held level set", 8'h02);
    doRead();
    tick();
    tick();
    checkByte("R2 held level no re-arm", 8'h01);
    reqIn = '0;
    tick();

    // R7: other source rises during read of receive ready
    reqIn = 5'b00010;
    tick();
    reqIn = '0;
    checkByte("R7 setup", 8'h04);
    reqIn = 5'b00001;
    doRead();
    reqIn = '0;
    checkByte("R7 new line event kept", 8'h06);
    doRead();
    checkByte("R7 drained", 8'h01);

    // R7: same source rises during its own read
    reqIn = 5'b01000;
    tick();
    reqIn = '0;
    tick();
    reqIn = 5'b01000;
    doRead();
    reqIn = '0;
    checkByte("R7 same-source event kept", 8'h02);
    doRead();
    checkByte("R7 same-source drained", 8'h01);

    // R1: reset in mid-run clears pending events
    reqIn = 5'b10001;
    tick();
    reqIn = '0;
    checkByte("R1 pre-reset pending", 8'h06);
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    checkByte("R1 reset clears", 8'h01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule